// File: doc/BRIEF.md
# Dual DAC Register Interface

This block is the register front end for a pair of 12-bit digital-to-analog converter channels attached to an 8-bit special-function-register bus. Software programs each channel's code through a low and a high data byte and sets up both channels through one shared control byte. Each channel has its own output latch, and that latch, not the data registers, drives the converter code. The control byte also carries, per channel, a range select, an active-low clear and a power enable, along with a mode bit and a synchronisation bit that both channels share.

The synchronisation bit is tracked by a two-state machine. In state `ST_LIVE` (sync bit 1) a write to a channel's low byte loads that channel's latch at once, so software writes the high byte first. The transition `T_PAUSE` is a control write with sync 0, and it moves the machine to `ST_HOLD`. In that state data writes only update the registers. The transition `T_COMMIT` is a control write with sync 1 made while in `ST_HOLD`. It returns the machine to `ST_LIVE` and loads both latches in the same clock cycle. A control write in `ST_LIVE` that keeps sync at 1 stays in `ST_LIVE` and loads nothing. Clear and power gating sit after the latch, so they never destroy a held code.

Top module: `dual_dac_regif`

## Requirements
- R1: After reset the control byte reads 04h and all four data bytes read 00h. Both codes are 0, both enables are 0 and both range outputs are 0.
- R2: The address map is: channel 0 low F9h, channel 0 high FAh, channel 1 low FBh, channel 1 high FCh, control FDh. A read strobe returns the stored byte, all eight bits, on the read data port one cycle later.
- R3: A read of any other address returns 00h. A write to any other address changes no register and no output.
- R4: In 12-bit mode (control bit 7 = 0) a channel's latch loads {high[3:0], low[7:0]}. With sync (control bit 2) at 1, a write to the channel's low byte loads the latch on that clock edge.
- R5: A write to a high byte alone never changes either output code.
- R6: With sync at 0, data writes leave both codes unchanged. A control write that takes sync from 0 to 1 loads both latches on the same edge, using the mode bit written in that same control write.
- R7: A control write with sync at 1 while sync is already 1 loads neither latch.
- R8: In 8-bit mode (control bit 7 = 1) a latch loads {low[7:0], 4'b0000}. The mode that applies is the one in force when the load happens.
- R9: Control bits 4 and 3 are active-low clears for channel 1 and channel 0. While a clear bit is 0 that channel's code output is 0. When the bit returns to 1, the latched code reappears unchanged.
- R10: Control bits 1 and 0 are the power enables for channel 1 and channel 0 and are driven on dac_en. A powered-off channel outputs code 0, and its registers and latch are kept.
- R11: Control bits 6 and 5 drive dac_range[1] and dac_range[0]. A value of 1 means the supply range and 0 means the reference range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_rd | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Read data, valid the cycle after sfr_rd |
| dac_code | output | 24 | Channel codes: channel c in bits [12c+11:12c] |
| dac_range | output | 2 | Range select per channel (1 = supply) |
| dac_en | output | 2 | Power enable per channel |

## Verification
The assertions assume that the bus carries at most one write per cycle and never raises the read and write strobes together. The "no change" checks on dac_code depend on this, because a control write in the same cycle could alter the gating. The assertions also assume that the strobes are held low during reset. The bench drives every access through single-cycle write and read tasks. It changes the inputs only at falling clock edges, so these assumptions hold throughout the run.

// File: rtl/ddac_pkg.sv
package ddac_pkg;
    localparam int DW    = 8;
    localparam int CW    = 12;
    localparam int NCH   = 2;
    localparam int NREG  = 2 * NCH + 1;
    localparam int CTRL_OFS = 2 * NCH;

    localparam int B_PWR0 = 0;
    localparam int B_SYNC = 2;
    localparam int B_CLR0 = 3;
    localparam int B_RNG0 = 5;
    localparam int B_MODE = 7;

    localparam logic [DW-1:0] CTRL_RST = 8'h04;

    typedef enum logic {
        ST_LIVE = 1'b0,
        ST_HOLD = 1'b1
    } sync_state_t;
endpackage

// File: rtl/ddac_regfile.sv
module ddac_regfile
    import ddac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hF9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wr,
    input  logic                     rd,
    output logic [DW-1:0]            rdata,
    output logic [NCH-1:0][DW-1:0]   lo_q,
    output logic [NCH-1:0][DW-1:0]   hi_q,
    output logic [DW-1:0]            ctrl_q,
    output logic [NCH-1:0]           wr_lo,
    output logic                     wr_ctrl
);
    logic [ADDR_W-1:0] ofs;
    logic              hit;
    logic [NCH-1:0]    wr_hi;
    logic [DW-1:0]     rd_val;

    assign ofs     = addr - BASE_ADDR;
    assign hit     = (addr >= BASE_ADDR) && (ofs < ADDR_W'(NREG));
    assign wr_ctrl = wr && hit && (ofs == ADDR_W'(CTRL_OFS));

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign wr_lo[c] = wr && hit && (ofs == ADDR_W'(2 * c));
        assign wr_hi[c] = wr && hit && (ofs == ADDR_W'(2 * c + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[c] <= '0;
                hi_q[c] <= '0;
            end else begin
                if (wr_lo[c]) lo_q[c] <= wdata;
                if (wr_hi[c]) hi_q[c] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    always_comb begin
        rd_val = '0;
        if (hit) begin
            for (int c = 0; c < NCH; c++) begin
                if (ofs == ADDR_W'(2 * c))     rd_val = lo_q[c];
                if (ofs == ADDR_W'(2 * c + 1)) rd_val = hi_q[c];
            end
            if (ofs == ADDR_W'(CTRL_OFS)) rd_val = ctrl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    // R2: one write strobe decodes to at most one register
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_lo, wr_hi, wr_ctrl}) <= 1);
endmodule

// File: rtl/ddac_sync_fsm.sv
module ddac_sync_fsm
    import ddac_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ctrl,
    input  logic           sync_bit,
    input  logic [NCH-1:0] wr_lo,
    output logic [NCH-1:0] ld,
    output logic           live
);
    sync_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LIVE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        ld  = '0;
        unique case (state)
            ST_LIVE: begin
                ld = wr_lo;
                if (wr_ctrl && !sync_bit) nxt = ST_HOLD;   // T_PAUSE
            end
            ST_HOLD: begin
                if (wr_ctrl && sync_bit) begin            // T_COMMIT
                    nxt = ST_LIVE;
                    ld  = '1;
                end
            end
            default: nxt = ST_LIVE;
        endcase
    end

    assign live = (state == ST_LIVE);

    // R7: a control write while live never loads a latch
    a_r7_live_ctrl_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LIVE && wr_ctrl) |-> (ld == '0));
    // R6: a load while holding always hits both channels together
    a_r6_commit_all: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && ld != '0) |-> (ld == '1));
endmodule

// File: rtl/ddac_channel.sv
module ddac_channel
    import ddac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          mode8,
    input  logic [DW-1:0] lo_src,
    input  logic [3:0]    hi_src,
    input  logic          clr_n,
    input  logic          pwr,
    output logic [CW-1:0] code,
    output logic          en
);
    logic [CW-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else if (ld) latch_q <= mode8 ? {lo_src, 4'b0000} : {hi_src, lo_src};
    end

    assign code = (pwr && clr_n) ? latch_q : '0;
    assign en   = pwr;
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import ddac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hF9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic [DW-1:0]       sfr_wdata,
    input  logic                sfr_wr,
    input  logic                sfr_rd,
    output logic [DW-1:0]       sfr_rdata,
    output logic [NCH*CW-1:0]   dac_code,
    output logic [NCH-1:0]      dac_range,
    output logic [NCH-1:0]      dac_en
);
    logic [NCH-1:0][DW-1:0] lo_q, hi_q;
    logic [DW-1:0]          ctrl_q;
    logic [NCH-1:0]         wr_lo, ld;
    logic                   wr_ctrl, live, mode_src;

    ddac_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wdata(sfr_wdata),
        .wr(sfr_wr), .rd(sfr_rd), .rdata(sfr_rdata),
        .lo_q(lo_q), .hi_q(hi_q), .ctrl_q(ctrl_q),
        .wr_lo(wr_lo), .wr_ctrl(wr_ctrl)
    );

    ddac_sync_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
        .sync_bit(sfr_wdata[B_SYNC]), .wr_lo(wr_lo), .ld(ld), .live(live)
    );

    assign mode_src = wr_ctrl ? sfr_wdata[B_MODE] : ctrl_q[B_MODE];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] lo_src;
        assign lo_src       = wr_lo[c] ? sfr_wdata : lo_q[c];
        assign dac_range[c] = ctrl_q[B_RNG0 + c];

        ddac_channel u_ch (
            .clk(clk), .rst_n(rst_n), .ld(ld[c]), .mode8(mode_src),
            .lo_src(lo_src), .hi_src(hi_q[c][3:0]),
            .clr_n(ctrl_q[B_CLR0 + c]), .pwr(ctrl_q[B_PWR0 + c]),
            .code(dac_code[c*CW +: CW]), .en(dac_en[c])
        );

        // R5: a high-byte write leaves every code as it was
        a_r5_hi_write_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
            (sfr_wr && sfr_addr == BASE_ADDR + ADDR_W'(2 * c + 1)) |=> $stable(dac_code));
        // R10: a disabled channel drives zero
        a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !dac_en[c] |-> (dac_code[c*CW +: CW] == '0));
    end

    // R6: machine state mirrors the stored sync bit
    a_r6_state_tracks_sync: assert property (@(posedge clk) disable iff (!rst_n)
        live == ctrl_q[B_SYNC]);
    // R6: while held and control untouched, codes do not move
    a_r6_hold_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_SYNC] && !wr_ctrl) |=> $stable(dac_code));
    // R3: unmapped reads return zero
    a_r3_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && (sfr_addr < BASE_ADDR || sfr_addr > BASE_ADDR + ADDR_W'(CTRL_OFS)))
        |=> (sfr_rdata == '0));
endmodule

// File: tb/tb_dual_dac_regif.sv
`timescale 1ns/1ps
module tb_dual_dac_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        sfr_wr = 1'b0;
    logic        sfr_rd = 1'b0;
    logic [7:0]  sfr_rdata;
    logic [23:0] dac_code;
    logic [1:0]  dac_range;
    logic [1:0]  dac_en;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    dual_dac_regif dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
        .dac_code(dac_code), .dac_range(dac_range), .dac_en(dac_en)
    );

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        sfr_addr = a; sfr_rd = 1'b1;
        @(negedge clk);
        sfr_rd = 1'b0;
        chk(tag, {16'h0, sfr_rdata}, {16'h0, exp});
    endtask

    function automatic logic [23:0] codes(input logic [11:0] c1, input logic [11:0] c0);
        return {c1, c0};
    endfunction

    task automatic t_reset;
        chk("R1 codes", dac_code, 24'h0);
        chk("R1 en", {22'h0, dac_en}, 24'h0);
        chk("R1 range", {22'h0, dac_range}, 24'h0);
        rd_chk("R1 ctrl", 8'hFD, 8'h04);
        rd_chk("R1 lo0", 8'hF9, 8'h00);
        rd_chk("R1 hi0", 8'hFA, 8'h00);
        rd_chk("R1 lo1", 8'hFB, 8'h00);
        rd_chk("R1 hi1", 8'hFC, 8'h00);
    endtask

    task automatic t_immediate;
        wr_reg(8'hFD, 8'h1F);
        chk("R10 en on", {22'h0, dac_en}, 24'h3);
        wr_reg(8'hFA, 8'hA5);
        chk("R5 hi first", dac_code, 24'h0);
        wr_reg(8'hF9, 8'h3C);
        chk("R4 ch0 load", dac_code, codes(12'h000, 12'h53C));
        wr_reg(8'hFC, 8'h07);
        wr_reg(8'hFB, 8'hFF);
        chk("R4 ch1 load", dac_code, codes(12'h7FF, 12'h53C));
        rd_chk("R2 hi0 full byte", 8'hFA, 8'hA5);
        rd_chk("R2 lo1", 8'hFB, 8'hFF);
    endtask

    task automatic t_hi_only;
        wr_reg(8'hFA, 8'h02);
        chk("R5 hi alone", dac_code, codes(12'h7FF, 12'h53C));
    endtask

    task automatic t_sync;
        wr_reg(8'hFD, 8'h1B);
        wr_reg(8'hFA, 8'h0C);
        wr_reg(8'hF9, 8'h11);
        wr_reg(8'hFC, 8'h01);
        wr_reg(8'hFB, 8'h22);
        chk("R6 held", dac_code, codes(12'h7FF, 12'h53C));
        wr_reg(8'hFD, 8'h1F);
        chk("R6 joint load", dac_code, codes(12'h122, 12'hC11));
    endtask

    task automatic t_no_retrigger;
        wr_reg(8'hFA, 8'h03);
        wr_reg(8'hFD, 8'h1F);
        chk("R7 no reload", dac_code, codes(12'h122, 12'hC11));
    endtask

    task automatic t_8bit;
        wr_reg(8'hFD, 8'h9F);
        wr_reg(8'hFB, 8'hAB);
        chk("R8 8-bit", dac_code, codes(12'hAB0, 12'hC11));
        wr_reg(8'hFD, 8'h1F);
        chk("R8 mode at load", dac_code, codes(12'hAB0, 12'hC11));
        wr_reg(8'hFB, 8'h22);
        chk("R8 back to 12", dac_code, codes(12'h122, 12'hC11));
    endtask

    task automatic t_clear;
        wr_reg(8'hFD, 8'h17);
        chk("R9 clr0", dac_code, codes(12'h122, 12'h000));
        chk("R9 en kept", {22'h0, dac_en}, 24'h3);
        wr_reg(8'hFD, 8'h1F);
        chk("R9 restore", dac_code, codes(12'h122, 12'hC11));
        wr_reg(8'hFD, 8'h0F);
        chk("R9 clr1", dac_code, codes(12'h000, 12'hC11));
        wr_reg(8'hFD, 8'h1F);
    endtask

    task automatic t_power;
        wr_reg(8'hFD, 8'h1D);
        chk("R10 off code", dac_code, codes(12'h000, 12'hC11));
        chk("R10 off en", {22'h0, dac_en}, 24'h1);
        rd_chk("R10 reg kept", 8'hFB, 8'h22);
        wr_reg(8'hFD, 8'h1F);
        chk("R10 on again", dac_code, codes(12'h122, 12'hC11));
    endtask

    task automatic t_range;
        wr_reg(8'hFD, 8'h7F);
        chk("R11 both", {22'h0, dac_range}, 24'h3);
        wr_reg(8'hFD, 8'h3F);
        chk("R11 ch0 only", {22'h0, dac_range}, 24'h1);
    endtask

    task automatic t_unmapped;
        rd_chk("R3 read F8", 8'hF8, 8'h00);
        wr_reg(8'hFE, 8'h55);
        rd_chk("R3 read FE", 8'hFE, 8'h00);
        chk("R3 codes kept", dac_code, codes(12'h122, 12'hC11));
        rd_chk("R3 ctrl kept", 8'hFD, 8'h3F);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_hi_only();
        t_sync();
        t_no_retrigger();
        t_8bit();
        t_clear();
        t_power();
        t_range();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule